// File: doc/BRIEF.md
# Burst Disconnect Boundary Detector

This block sits on the target side of a parallel bus and follows the address of every data phase inside a burst. When the transfer being accepted is the one that takes the address up to a programmable block boundary, it raises a disconnect flag in that same data phase. The target therefore ends the burst together with its last data, and the master has to restart at the boundary address.

The boundary is chosen when each burst opens. A 2-bit select picks one of four large block sizes. A line-mode enable overrides the select with a fixed 16-byte line. Every data phase moves 4 bytes. The block only tracks addresses and detects the boundary; bus handshakes, data storage and register decoding belong elsewhere.

Control is a two-state machine. `ST_IDLE` means no burst is open. `ST_ACTIVE` means a burst is being tracked. The transitions are as follows. OPEN goes from `ST_IDLE` to `ST_ACTIVE` on a burst start. RESTART goes from `ST_ACTIVE` to `ST_ACTIVE` on a burst start and reloads the address and the boundary. ADVANCE goes from `ST_ACTIVE` to `ST_ACTIVE` on a data phase that does not reach the boundary. FINISH goes from `ST_ACTIVE` to `ST_IDLE` on the data phase that raises the disconnect. The machine stays in `ST_IDLE` otherwise.

Top module: `burst_boundary_guard`

## Requirements
- R1: With line mode off, the boundary select is decoded as 0 = 128 bytes, 1 = 256 bytes, 2 = 512 bytes, 3 = 1024 bytes.
- R2: With line mode on, the boundary is 16 bytes and the value of the boundary select has no effect.
- R3: `disc_o` is high in the same cycle as an accepted data phase exactly when the current address plus 4 is a multiple of the boundary. It is low in every other accepted data phase of the burst.
- R4: `cur_addr_o` is loaded on a burst start with `start_addr_i` and bits [1:0] forced to zero. It advances by 4 on each accepted data phase and holds in cycles without one.
- R5: A burst whose start address is one word below a boundary raises `disc_o` on its first data phase.
- R6: The boundary select and line mode are sampled only on a burst start. Changing them during a burst does not move that burst's disconnect.
- R7: After the disconnect phase the burst is closed. Later data-phase strobes raise no `disc_o` and leave `cur_addr_o` unchanged until the next burst start.
- R8: A burst start while a burst is open restarts tracking at the new address. A data-phase strobe in the same cycle as any burst start is not accepted and raises no `disc_o`.
- R9: Reset (active-low `rst_n`) closes any burst, sets `cur_addr_o` to 0 and holds `disc_o` low.
- R10: `disc_o` is never high in a cycle where `phase_i` is low.
- R11: The tracked address wraps from the top of the address space to 0, and 0 counts as aligned to every boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| burst_start_i | input | 1 | Opens (or reopens) a burst; samples address and boundary setting |
| start_addr_i | input | ADDR_W (32) | Byte address of the first data phase |
| phase_i | input | 1 | Data-phase strobe: one 4-byte transfer completes this cycle |
| blk_sel_i | input | 2 | Boundary select, 128/256/512/1024 bytes |
| line_mode_i | input | 1 | 1 forces a 16-byte boundary |
| disc_o | output | 1 | Disconnect with this data phase |
| cur_addr_o | output | ADDR_W (32) | Byte address of the current data phase |

## Verification
The main check runs bursts from many start offsets under every select value and under line mode, and counts the data phases until the disconnect. Aligned starts confirm the full block length for each size. Starts one word below a boundary separate a detector that compares the next address from one that compares the current address. A line-mode start whose 16-byte and 512-byte distances differ shows whether the select is really ignored. Directed runs change the setting in mid-burst, insert idle gaps, restart a burst over a boundary-hitting phase, keep strobing after the disconnect, and cross the top of the address space.

// File: rtl/bbg_pkg.sv
package bbg_pkg;

    typedef enum logic [0:0] {
        ST_IDLE   = 1'b0,
        ST_ACTIVE = 1'b1
    } bbg_state_e;

    // Vector with the n lowest bits set.
    function automatic logic [63:0] low_ones(input int unsigned n);
        logic [63:0] r;
        r = '0;
        for (int i = 0; i < 64; i++) begin
            if (i < n) r[i] = 1'b1;
        end
        return r;
    endfunction

endpackage

// File: rtl/bbg_cfg_latch.sv
module bbg_cfg_latch
    import bbg_pkg::*;
#(
    parameter int WA_W    = 30,
    parameter int LINE_SH = 2,
    parameter int BLK_SH  = 5,
    parameter int N_SEL   = 4,
    parameter int SEL_W   = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [SEL_W-1:0] blk_sel_i,
    input  logic             line_mode_i,
    output logic [WA_W-1:0]  mask_o
);

    logic [WA_W-1:0] sel_mask [N_SEL];
    logic [WA_W-1:0] line_mask;
    logic [WA_W-1:0] mask_d;
    logic [WA_W-1:0] mask_q;

    // One word-mask per block size: each step doubles the block.
    for (genvar g = 0; g < N_SEL; g++) begin : g_sel
        assign sel_mask[g] = WA_W'(low_ones(BLK_SH + g));
    end

    assign line_mask = WA_W'(low_ones(LINE_SH));

    always_comb begin
        if (line_mode_i) mask_d = line_mask;
        else             mask_d = sel_mask[blk_sel_i];
    end

    always_ff @(posedge clk) begin
        if (!rst_n)      mask_q <= sel_mask[0];
        else if (load_i) mask_q <= mask_d;
    end

    assign mask_o = mask_q;

    // R6: setting is frozen between burst starts
    p_cfg_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !load_i |=> $stable(mask_q));

    // R2: a line-mode load always yields the short mask
    p_line_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (load_i && line_mode_i) |=> (mask_q == line_mask));

endmodule

// File: rtl/bbg_addr_track.sv
module bbg_addr_track #(
    parameter int WA_W = 30
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load_i,
    input  logic [WA_W-1:0] start_word_i,
    input  logic            step_i,
    output logic [WA_W-1:0] word_o
);

    logic [WA_W-1:0] word_q;

    always_ff @(posedge clk) begin
        if (!rst_n)       word_q <= '0;
        else if (load_i)  word_q <= start_word_i;
        else if (step_i)  word_q <= word_q + WA_W'(1);
    end

    assign word_o = word_q;

    // R4: one word per accepted phase
    p_addr_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !load_i) |=> (word_q == $past(word_q) + WA_W'(1)));

    // R4: no movement without a phase
    p_addr_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!step_i && !load_i) |=> $stable(word_q));

    // R4: load takes the new start
    p_addr_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (word_q == $past(start_word_i)));

endmodule

// File: rtl/bbg_bound_cmp.sv
module bbg_bound_cmp #(
    parameter int WA_W = 30
) (
    input  logic [WA_W-1:0] word_i,
    input  logic [WA_W-1:0] mask_i,
    output logic            hit_o
);

    logic [WA_W-1:0] next_word;

    // Boundary is reached when the word after this transfer is aligned.
    always_comb begin
        next_word = word_i + WA_W'(1);
        hit_o     = ((next_word & mask_i) == '0);
    end

endmodule

// File: rtl/burst_boundary_guard.sv
module burst_boundary_guard
    import bbg_pkg::*;
#(
    parameter int ADDR_W        = 32,
    parameter int WORD_BYTES    = 4,
    parameter int LINE_BYTES    = 16,
    parameter int BLK_MIN_BYTES = 128,
    parameter int SEL_W         = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              burst_start_i,
    input  logic [ADDR_W-1:0] start_addr_i,
    input  logic              phase_i,
    input  logic [SEL_W-1:0]  blk_sel_i,
    input  logic              line_mode_i,
    output logic              disc_o,
    output logic [ADDR_W-1:0] cur_addr_o
);

    localparam int WORD_SH = $clog2(WORD_BYTES);
    localparam int WA_W    = ADDR_W - WORD_SH;
    localparam int LINE_SH = $clog2(LINE_BYTES) - WORD_SH;
    localparam int BLK_SH  = $clog2(BLK_MIN_BYTES) - WORD_SH;
    localparam int N_SEL   = 1 << SEL_W;

    bbg_state_e      state_q;
    bbg_state_e      state_d;
    logic [WA_W-1:0] word_q;
    logic [WA_W-1:0] mask_q;
    logic            hit;
    logic            accept;

    // ---------------- sub-blocks ----------------
    bbg_cfg_latch #(
        .WA_W    (WA_W),
        .LINE_SH (LINE_SH),
        .BLK_SH  (BLK_SH),
        .N_SEL   (N_SEL),
        .SEL_W   (SEL_W)
    ) cfg_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .load_i      (burst_start_i),
        .blk_sel_i   (blk_sel_i),
        .line_mode_i (line_mode_i),
        .mask_o      (mask_q)
    );

    bbg_addr_track #(
        .WA_W (WA_W)
    ) trk_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .load_i       (burst_start_i),
        .start_word_i (start_addr_i[ADDR_W-1:WORD_SH]),
        .step_i       (accept),
        .word_o       (word_q)
    );

    bbg_bound_cmp #(
        .WA_W (WA_W)
    ) cmp_i (
        .word_i (word_q),
        .mask_i (mask_q),
        .hit_o  (hit)
    );

    // ---------------- state register ----------------
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // ---------------- next state ----------------
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (burst_start_i) state_d = ST_ACTIVE;           // OPEN
            end
            ST_ACTIVE: begin
                if (burst_start_i)        state_d = ST_ACTIVE;    // RESTART
                else if (phase_i && hit)  state_d = ST_IDLE;      // FINISH
                else                      state_d = ST_ACTIVE;    // ADVANCE / wait
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // ---------------- outputs ----------------
    always_comb begin
        accept = 1'b0;
        disc_o = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                accept = 1'b0;
                disc_o = 1'b0;
            end
            ST_ACTIVE: begin
                accept = phase_i && !burst_start_i;
                disc_o = phase_i && !burst_start_i && hit;
            end
            default: begin
                accept = 1'b0;
                disc_o = 1'b0;
            end
        endcase
    end

    assign cur_addr_o = {word_q, {WORD_SH{1'b0}}};

    // ---------------- assertions ----------------
    // R10: flag only with a data phase
    p_flag_needs_phase_r10: assert property (@(posedge clk) disable iff (!rst_n)
        disc_o |-> phase_i);

    // R3: every boundary is a multiple of the line, so the next address is line aligned
    p_flag_aligned_r3: assert property (@(posedge clk) disable iff (!rst_n)
        disc_o |-> ((word_q + WA_W'(1)) & WA_W'(low_ones(LINE_SH))) == '0);

    // R7: disconnect closes the burst
    p_close_after_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
        disc_o |=> (state_q == ST_IDLE));

    // R7: closed burst never flags
    p_idle_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |-> !disc_o);

    // R8: start wins over a same-cycle phase
    p_start_blocks_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
        burst_start_i |-> !disc_o);

    // R8: start always leaves a burst open
    p_start_opens_r8: assert property (@(posedge clk) disable iff (!rst_n)
        burst_start_i |=> (state_q == ST_ACTIVE));

endmodule

// File: tb/burst_boundary_guard_tb_top.sv
module burst_boundary_guard_tb_top;

    localparam int  AW      = 32;
    localparam time TCLK    = 8ns;
    localparam int  MAXPH   = 300;

    typedef struct packed {
        logic [31:0] addr;
        logic [1:0]  sel;
        logic        line;
        logic [9:0]  nph;   // expected data phase (1-based) carrying the disconnect
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VECS [NV] = '{
        '{32'h0000_0000, 2'd0, 1'b0, 10'd32},  // R1 128 aligned
        '{32'h0000_007C, 2'd0, 1'b0, 10'd1 },  // R5 one word before 128
        '{32'h0000_0100, 2'd1, 1'b0, 10'd64},  // R1 256 aligned
        '{32'h0000_01F0, 2'd2, 1'b0, 10'd4 },  // R1 512
        '{32'h0000_03F8, 2'd3, 1'b0, 10'd2 },  // R1 1024
        '{32'h0000_0004, 2'd3, 1'b1, 10'd3 },  // R2 line, sel ignored
        '{32'h0000_000C, 2'd0, 1'b1, 10'd1 },  // R5 line
        '{32'h0000_0080, 2'd0, 1'b0, 10'd32},  // R1 128 second block
        '{32'h0000_07FC, 2'd3, 1'b0, 10'd1 },  // R5 1024
        '{32'h0000_0206, 2'd1, 1'b0, 10'd63},  // R4 low bits dropped
        '{32'h0000_00F0, 2'd2, 1'b1, 10'd4 },  // R2 would be 68 at 512
        '{32'hFFFF_FFFC, 2'd0, 1'b0, 10'd1 }   // R11 wrap
    };

    logic          clk = 1'b0;
    logic          rst_n;
    logic          burst_start_i;
    logic [AW-1:0] start_addr_i;
    logic          phase_i;
    logic [1:0]    blk_sel_i;
    logic          line_mode_i;
    logic          disc_o;
    logic [AW-1:0] cur_addr_o;

    int n_checks = 0;
    int n_errors = 0;

    always #(TCLK/2) clk = ~clk;

    burst_boundary_guard dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .burst_start_i (burst_start_i),
        .start_addr_i  (start_addr_i),
        .phase_i       (phase_i),
        .blk_sel_i     (blk_sel_i),
        .line_mode_i   (line_mode_i),
        .disc_o        (disc_o),
        .cur_addr_o    (cur_addr_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    // Open a burst; returns at the negedge where the first phase may be driven.
    task automatic open_burst(input logic [31:0] a, input logic [1:0] s, input logic l);
        @(negedge clk);
        burst_start_i = 1'b1;
        start_addr_i  = a;
        blk_sel_i     = s;
        line_mode_i   = l;
        phase_i       = 1'b0;
        @(negedge clk);
        burst_start_i = 1'b0;
    endtask

    // Strobe phases back to back until the flag; returns its 1-based index or 0.
    task automatic run_phases(output int n);
        n = 0;
        for (int k = 1; k <= MAXPH; k++) begin
            phase_i = 1'b1;
            #1;
            if (disc_o) begin
                n = k;
                break;
            end
            @(negedge clk);
        end
        @(negedge clk);
        phase_i = 1'b0;
    endtask

    initial begin
        #(TCLK * 200000);
        n_errors++;
        $display("FAIL watchdog: actual 0x%08h expected 0x%08h", 32'd1, 32'd0);
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        int n;
        logic [31:0] base;
        rst_n = 1'b0; burst_start_i = 1'b0; start_addr_i = '0;
        phase_i = 1'b0; blk_sel_i = '0; line_mode_i = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R9 reset state
        check("R9 flag after reset", 32'(disc_o), 32'd0);
        check("R9 addr after reset", cur_addr_o, 32'd0);
        phase_i = 1'b1; #1;
        check("R7 strobe with no burst", 32'(disc_o), 32'd0);
        @(negedge clk); phase_i = 1'b0;

        // Vector table: R1 R2 R3 R4 R5 R11
        for (int v = 0; v < NV; v++) begin
            base = {VECS[v].addr[31:2], 2'b00};
            open_burst(VECS[v].addr, VECS[v].sel, VECS[v].line);
            #1;
            check("R4 start address", cur_addr_o, base);
            run_phases(n);
            check("R3 disconnect phase index", 32'(n), 32'(VECS[v].nph));
            check("R4 address at boundary", cur_addr_o, base + 32'(VECS[v].nph) * 4);
        end

        // R6: setting changed mid-burst
        open_burst(32'h0, 2'd0, 1'b0);
        phase_i = 1'b1; @(negedge clk); @(negedge clk);
        line_mode_i = 1'b1; blk_sel_i = 2'd3;
        run_phases(n);
        check("R6 mid-burst change ignored", 32'(n), 32'd30);

        // R10 / R4: gaps between phases (start 0x070, 128 block -> 4 phases)
        open_burst(32'h70, 2'd0, 1'b0);
        for (int k = 0; k < 3; k++) begin
            phase_i = 1'b1; #1;
            check("R3 no early flag", 32'(disc_o), 32'd0);
            @(negedge clk); phase_i = 1'b0; #1;
            check("R10 no flag without phase", 32'(disc_o), 32'd0);
            @(negedge clk); #1;
            check("R4 hold during gap", cur_addr_o, 32'h70 + 32'(k + 1) * 4);
        end
        phase_i = 1'b1; #1;
        check("R3 flag after gaps", 32'(disc_o), 32'd1);
        @(negedge clk); phase_i = 1'b0;

        // R7: strobes after the disconnect
        phase_i = 1'b1;
        for (int k = 0; k < 3; k++) begin
            #1;
            check("R7 closed burst no flag", 32'(disc_o), 32'd0);
            @(negedge clk);
        end
        phase_i = 1'b0; #1;
        check("R7 closed burst address", cur_addr_o, 32'h80);

        // R8: restart over a phase that would hit
        open_burst(32'h74, 2'd0, 1'b0);
        phase_i = 1'b1; @(negedge clk); @(negedge clk);
        burst_start_i = 1'b1; start_addr_i = 32'h3F8; blk_sel_i = 2'd3; #1;
        check("R8 start masks hitting phase", 32'(disc_o), 32'd0);
        @(negedge clk); burst_start_i = 1'b0; #1;
        check("R8 restart address", cur_addr_o, 32'h3F8);
        run_phases(n);
        check("R8 restarted burst length", 32'(n), 32'd2);

        // R9: reset in mid-burst
        open_burst(32'h40, 2'd0, 1'b0);
        phase_i = 1'b1; @(negedge clk);
        rst_n = 1'b0; @(negedge clk); rst_n = 1'b1; #1;
        check("R9 reset clears address", cur_addr_o, 32'd0);
        check("R9 reset closes burst", 32'(disc_o), 32'd0);
        phase_i = 1'b0;

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule